// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a general-purpose I/O controller with a parameterised number of pins (fewer than 32). It sits on a simple 32-bit register bus with a byte address, a write enable, write data and combinational read data. Software sets the direction of each pin, drives output levels through separate write-one-to-set and write-one-to-clear registers, and reads the synchronised pin levels. Pad buffers are outside the block: it exposes an output vector, an output-enable vector and an input vector.

Each pin carries its own interrupt configuration: a type bit chooses edge or level detection and a polarity bit chooses which level or edge is active. Detected events are latched into a pending register, gated by an enable register and a mask register, and combined into one registered interrupt line for a parent controller. A parameter inverts the sense of the direction register for integrations where a set bit means input.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, pinOut is zero, irqOut is low, and pinOutEn is all zeros when DIR_INVERT is 0 or all ones when DIR_INVERT is 1.
- R2: Writing to byte offset 0x0C sets every output bit whose write-data bit is 1 and leaves the others unchanged; reading 0x0C returns the current output levels.
- R3: Writing to byte offset 0x10 clears every output bit whose write-data bit is 1 and leaves the others unchanged; reading 0x10 returns zero.
- R4: The direction register at offset 0x00 reads back as written; pinOutEn equals it when DIR_INVERT is 0 and equals its complement when DIR_INVERT is 1.
- R5: Reading offset 0x04 returns pinIn through a two-flop synchronizer, so a pin change set up before one clock edge is visible in the read only after the second edge; writes to 0x04 have no effect.
- R6: With the type bit (offset 0x18) at 0 a pin is edge sensitive: polarity bit (offset 0x1C) 1 latches its pending bit (offset 0x20) on a rising edge, 0 on a falling edge; the opposite edge latches nothing, and no edge latches while its enable bit (offset 0x14) is 0.
- R7: An edge pending bit stays set until software writes 1 to that bit at offset 0x20; writing 0 to it has no effect.
- R8: With the type bit at 1 a pin is level sensitive: its pending bit is 1 while the pin is enabled and its synchronised level equals its polarity bit, and 0 otherwise, including whenever the pin is disabled.
- R9: irqOut is registered and is high one clock after any pin has pending, enable and mask (offset 0x24) bits all 1; a mask bit of 0 keeps that pin off irqOut without changing its pending bit.
- R10: Register bits at or above NUM_PINS read zero, any offset not listed above reads zero, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| pinIn | input | NUM_PINS | Pin levels from the pads |
| pinOut | output | NUM_PINS | Output levels to the pads |
| pinOutEn | output | NUM_PINS | Per-pin output enable to the pads |
| irqOut | output | 1 | Combined registered interrupt request |

## Verification
The assertions check on every cycle that set and clear writes land on exactly the written bits while outputs hold otherwise, that a level pin never reports pending while disabled, that an edge pending bit is never lost without a write-one clear, that irqOut never rises without an enabled and unmasked pin, and that the decoder issues at most one write strobe. Only the bench's scenarios can show the detection itself: which edge or level of each pin raises pending for each type and polarity, the exact synchronizer latency of input reads, the masking of irqOut, the inverted direction variant and the zero reads of undefined offsets.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Byte offsets of the register words; software depends on these values.
  localparam logic [7:0] OFS_DIR  = 8'h00;
  localparam logic [7:0] OFS_IN   = 8'h04;
  localparam logic [7:0] OFS_SET  = 8'h0C;
  localparam logic [7:0] OFS_CLR  = 8'h10;
  localparam logic [7:0] OFS_EN   = 8'h14;
  localparam logic [7:0] OFS_TYPE = 8'h18;
  localparam logic [7:0] OFS_POL  = 8'h1C;
  localparam logic [7:0] OFS_PEND = 8'h20;
  localparam logic [7:0] OFS_MASK = 8'h24;

  typedef enum logic [3:0] {
    RD_NONE, RD_DIR, RD_IN, RD_OUT, RD_EN, RD_TYPE, RD_POL, RD_PEND, RD_MASK
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrSet;
    logic   wrClr;
    logic   wrEn;
    logic   wrType;
    logic   wrPol;
    logic   wrPend;
    logic   wrMask;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strb
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_NONE;
    strb.wrDir  = busWrEn && hit(busAddr, OFS_DIR);
    strb.wrSet  = busWrEn && hit(busAddr, OFS_SET);
    strb.wrClr  = busWrEn && hit(busAddr, OFS_CLR);
    strb.wrEn   = busWrEn && hit(busAddr, OFS_EN);
    strb.wrType = busWrEn && hit(busAddr, OFS_TYPE);
    strb.wrPol  = busWrEn && hit(busAddr, OFS_POL);
    strb.wrPend = busWrEn && hit(busAddr, OFS_PEND);
    strb.wrMask = busWrEn && hit(busAddr, OFS_MASK);
    if      (hit(busAddr, OFS_DIR))  strb.rdSel = RD_DIR;
    else if (hit(busAddr, OFS_IN))   strb.rdSel = RD_IN;
    else if (hit(busAddr, OFS_SET))  strb.rdSel = RD_OUT;
    else if (hit(busAddr, OFS_EN))   strb.rdSel = RD_EN;
    else if (hit(busAddr, OFS_TYPE)) strb.rdSel = RD_TYPE;
    else if (hit(busAddr, OFS_POL))  strb.rdSel = RD_POL;
    else if (hit(busAddr, OFS_PEND)) strb.rdSel = RD_PEND;
    else if (hit(busAddr, OFS_MASK)) strb.rdSel = RD_MASK;
  end

  // R10: one access reaches at most one register
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDir, strb.wrSet, strb.wrClr, strb.wrEn,
              strb.wrType, strb.wrPol, strb.wrPend, strb.wrMask}));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter bit DIR_INVERT = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqOut
);

  localparam int PAD_W = 32 - NUM_PINS;

  logic [NUM_PINS-1:0] wrBits;
  logic [NUM_PINS-1:0] dirReg, outReg, enReg, typeReg, polReg, maskReg, pendReg;
  logic [NUM_PINS-1:0] syncA, syncB, prevB;
  logic [NUM_PINS-1:0] edgeHit, pendNext, keepMask;
  logic                irqReg;

  assign wrBits = wrData[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      outReg  <= '0;
      enReg   <= '0;
      typeReg <= '0;
      polReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strb.wrDir)  dirReg  <= wrBits;
      if (strb.wrSet)  outReg  <= outReg | wrBits;
      if (strb.wrClr)  outReg  <= outReg & ~wrBits;
      if (strb.wrEn)   enReg   <= wrBits;
      if (strb.wrType) typeReg <= wrBits;
      if (strb.wrPol)  polReg  <= wrBits;
      if (strb.wrMask) maskReg <= wrBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevB   <= '0;
      pendReg <= '0;
      irqReg  <= 1'b0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevB   <= syncB;
      pendReg <= pendNext;
      irqReg  <= |(pendReg & enReg & maskReg);
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign edgeHit[i] = polReg[i] ? (syncB[i] & ~prevB[i]) : (~syncB[i] & prevB[i]);
    assign pendNext[i] = typeReg[i]
      ? (enReg[i] & (syncB[i] == polReg[i]))
      : ((enReg[i] & edgeHit[i]) | (pendReg[i] & ~(strb.wrPend & wrBits[i])));
  end

  if (DIR_INVERT) begin : g_dir_inv
    assign pinOutEn = ~dirReg;
  end else begin : g_dir_norm
    assign pinOutEn = dirReg;
  end

  assign pinOut = outReg;
  assign irqOut = irqReg;

  always_comb begin
    unique case (strb.rdSel)
      RD_DIR:  rdData = {{PAD_W{1'b0}}, dirReg};
      RD_IN:   rdData = {{PAD_W{1'b0}}, syncB};
      RD_OUT:  rdData = {{PAD_W{1'b0}}, outReg};
      RD_EN:   rdData = {{PAD_W{1'b0}}, enReg};
      RD_TYPE: rdData = {{PAD_W{1'b0}}, typeReg};
      RD_POL:  rdData = {{PAD_W{1'b0}}, polReg};
      RD_PEND: rdData = {{PAD_W{1'b0}}, pendReg};
      RD_MASK: rdData = {{PAD_W{1'b0}}, maskReg};
      default: rdData = '0;
    endcase
  end

  // Edge pending bits that must survive this cycle
  always_comb keepMask = pendReg & ~typeReg & ~(strb.wrPend ? wrBits : '0);

  // R2: a set write raises every written bit
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> ((outReg & $past(wrBits)) == $past(wrBits)));

  // R3: a clear write lowers every written bit
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((outReg & $past(wrBits)) == '0));

  // R3: without a set or clear write the outputs hold
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrSet || strb.wrClr) |=> $stable(outReg));

  // R7: an edge pending bit is only lost through a write-one clear
  a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendReg & $past(keepMask)) == $past(keepMask)));

  // R8: a disabled level pin never reports pending
  a_r8_level_disabled: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendReg & $past(typeReg & ~enReg)) == '0));

  // R9: the interrupt needs an enabled, unmasked pin one cycle earlier
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(enReg & maskReg)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 8,     // must be below 32
  parameter bit DIR_INVERT = 1'b0,  // 1: a set direction bit means input
  parameter int ADDR_W     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqOut
);

  ctrlStrobe_t strb;

  gpio_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS), .DIR_INVERT(DIR_INVERT)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;

  localparam int N = 8;
  localparam logic [31:0] ALL = 32'h0000_00FF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [N-1:0]  pinIn = '0;
  logic [31:0]   rdata, rdata2;
  logic [N-1:0]  pinOut, pinOutEn, pinOut2, pinOutEn2;
  logic          irq, irq2;
  int            nChecks = 0;
  int            nFail = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N), .DIR_INVERT(1'b0)) dut (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWrEn(we), .busWrData(wdata),
    .busRdData(rdata), .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irq));

  gpio_irq_ctrl #(.NUM_PINS(N), .DIR_INVERT(1'b1)) dut2 (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWrEn(we), .busWrData(wdata),
    .busRdData(rdata2), .pinIn(pinIn), .pinOut(pinOut2), .pinOutEn(pinOutEn2), .irqOut(irq2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(input int i, input logic v);
    @(negedge clk);
    pinIn[i] = v;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] bit1;
    logic [7:0]  offs [9];
    offs = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1: reset state
    for (int k = 0; k < 9; k++) begin
      rd(offs[k], d);
      chk($sformatf("R1 reset read of %h", offs[k]), d, 0);
    end
    chk("R1 pinOut after reset", pinOut, 0);
    chk("R1 irqOut after reset", irq, 0);
    chk("R1 pinOutEn normal variant", pinOutEn, 0);
    chk("R1 pinOutEn inverted variant", pinOutEn2, ALL);

    // R4: direction sweep in both variants
    for (int v = 0; v < 256; v += 17) begin
      wr(8'h00, v);
      rd(8'h00, d);
      chk("R4 direction readback", d, v);
      chk("R4 pinOutEn normal", pinOutEn, v);
      chk("R4 pinOutEn inverted", pinOutEn2, (~v) & ALL);
    end

    // R2 / R3: exhaustive set patterns from cleared outputs
    for (int v = 0; v < 256; v++) begin
      wr(8'h10, ALL);
      wr(8'h0C, v);
      chk("R2 set from zero", pinOut, v);
    end
    // R3: exhaustive clear patterns from all-ones outputs
    for (int v = 0; v < 256; v++) begin
      wr(8'h0C, ALL);
      wr(8'h10, v);
      chk("R3 clear from ones", pinOut, (~v) & ALL);
    end
    wr(8'h10, ALL);
    wr(8'h0C, 32'h05);
    wr(8'h0C, 32'h02);
    chk("R2 set accumulates", pinOut, 8'h07);
    wr(8'h10, 32'h04);
    wr(8'h10, 32'h00);
    chk("R3 clear zero bits keep", pinOut, 8'h03);
    wr(8'h0C, 32'h00);
    chk("R2 set zero bits keep", pinOut, 8'h03);
    rd(8'h0C, d);
    chk("R2 read of set offset", d, 8'h03);
    rd(8'h10, d);
    chk("R3 read of clear offset", d, 0);

    // R10: upper bits, undefined offsets
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d);
    chk("R10 bits above NUM_PINS", d, ALL);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h08, d);
    chk("R10 undefined offset 08", d, 0);
    rd(8'h28, d);
    chk("R10 undefined offset 28", d, 0);
    chk("R10 undefined writes leave outputs", pinOut, 8'h03);
    rd(8'h14, d);
    chk("R10 undefined writes leave enable", d, 0);

    // R5: synchronizer latency and read-only input
    @(negedge clk);
    pinIn = 8'hA5;
    addr = 8'h04;
    @(negedge clk);
    #1 chk("R5 input after one edge", rdata, 0);
    @(negedge clk);
    #1 chk("R5 input after two edges", rdata, 8'hA5);
    wr(8'h04, 32'h3C);
    rd(8'h04, d);
    chk("R5 write to input ignored", d, 8'hA5);
    @(negedge clk);
    pinIn = '0;
    waitClk(4);

    // R6 / R7 / R9: edge mode sweep, every pin and polarity
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 2; p++) begin
        bit1 = 32'(1) << i;
        wr(8'h14, 0);
        wr(8'h18, 0);
        wr(8'h1C, p ? bit1 : 0);
        wr(8'h24, bit1);
        setPin(i, ~p[0]);
        waitClk(5);
        wr(8'h20, ALL);
        waitClk(2);
        setPin(i, p[0]);
        waitClk(5);
        rd(8'h20, d);
        chk($sformatf("R6 pin %0d pol %0d disabled edge", i, p), d, 0);
        setPin(i, ~p[0]);
        waitClk(5);
        wr(8'h14, bit1);
        setPin(i, p[0]);
        waitClk(5);
        rd(8'h20, d);
        chk($sformatf("R6 pin %0d pol %0d active edge", i, p), d, bit1);
        chk($sformatf("R9 pin %0d pol %0d irq on edge", i, p), irq, 1);
        wr(8'h20, 0);
        rd(8'h20, d);
        chk($sformatf("R7 pin %0d write zero keeps", i), d, bit1);
        wr(8'h20, (~bit1) & ALL);
        rd(8'h20, d);
        chk($sformatf("R7 pin %0d other bits keep", i), d, bit1);
        wr(8'h20, bit1);
        waitClk(3);
        rd(8'h20, d);
        chk($sformatf("R7 pin %0d write one clears", i), d, 0);
        chk($sformatf("R9 pin %0d irq drops", i), irq, 0);
        setPin(i, ~p[0]);
        waitClk(5);
        rd(8'h20, d);
        chk($sformatf("R6 pin %0d pol %0d opposite edge", i, p), d, 0);
      end
    end

    // R8 / R9: level mode sweep
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 2; p++) begin
        bit1 = 32'(1) << i;
        wr(8'h14, 0);
        wr(8'h20, ALL);
        wr(8'h18, bit1);
        wr(8'h1C, p ? bit1 : 0);
        wr(8'h24, bit1);
        wr(8'h14, bit1);
        setPin(i, p[0]);
        waitClk(5);
        rd(8'h20, d);
        chk($sformatf("R8 pin %0d pol %0d active level", i, p), d, bit1);
        chk($sformatf("R9 pin %0d level irq", i), irq, 1);
        wr(8'h24, 0);
        waitClk(3);
        chk($sformatf("R9 pin %0d masked irq", i), irq, 0);
        rd(8'h20, d);
        chk($sformatf("R9 pin %0d mask keeps pending", i), d, bit1);
        wr(8'h24, bit1);
        setPin(i, ~p[0]);
        waitClk(5);
        rd(8'h20, d);
        chk($sformatf("R8 pin %0d pol %0d inactive level", i, p), d, 0);
        chk($sformatf("R9 pin %0d inactive irq", i), irq, 0);
        setPin(i, p[0]);
        waitClk(5);
        wr(8'h14, 0);
        waitClk(3);
        rd(8'h20, d);
        chk($sformatf("R8 pin %0d disabled level", i), d, 0);
        chk($sformatf("R9 pin %0d disabled irq", i), irq, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule